// File: doc/BRIEF.md
# Clock-Loss Power-Down Supervisor

This block sits beside a converter datapath and decides, from a free-running reference clock, whether that datapath may run. It watches three incoming clocks: a master clock, a bit clock and a word clock. Each one is resynchronised into the reference domain, and its transitions are turned into single-cycle edge pulses. The block drives a power-down control and an output high-impedance enable toward the datapath. It also drives a regulator enable that never drops.

Start-up and dropout use different rules. After reset is released, the datapath stays powered down until every one of the three clocks has proven itself active. Once running, only the master clock is supervised. If the master clock goes quiet for a fixed timeout (TIMEOUT_CYC reference cycles, 100 cycles of a 100 MHz reference for one microsecond), the datapath is forced into power-down. It is released again as soon as the master clock returns, with no need to re-check the other two clocks. A sticky flag records that a dropout happened, and a clear pulse resets it. The datapath's configuration storage is outside this block and is never reset by a dropout.

Top module: `clk_loss_supervisor`

## Requirements
- R1: While `rst_n` is low at a reference clock edge, the following cycle shows `status` = 2'b00, `power_down` = 1, `out_hiz` = 1 and `loss_sticky` = 0.
- R2: `ldo_en` is 1 in every state, including reset and clock-loss power-down.
- R3: After reset release, `status` reads 2'b01 and `power_down` stays 1 until each of master, bit and word clock has shown at least two edges within one TIMEOUT_CYC window; then `status` becomes 2'b10 and `power_down` becomes 0.
- R4: A clock whose successive edges are more than TIMEOUT_CYC reference cycles apart is never counted as active, so the block stays waiting.
- R5: While running, if the master clock shows no edge for TIMEOUT_CYC reference cycles, `status` becomes 2'b01 and `power_down` becomes 1. Stopping the bit clock or the word clock alone causes no power-down.
- R6: After a clock-loss power-down, the return of master clock edges alone brings `status` back to 2'b10 and `power_down` to 0.
- R7: Master clock edges that arrive closer together than TIMEOUT_CYC reference cycles keep the block running. A gap of fewer than 90 cycles after the last edge causes no power-down.
- R8: `power_down` and `out_hiz` are registered outputs that are equal to each other. Each is 0 exactly one cycle after the internal state is running.
- R9: `loss_sticky` sets when a running block loses its master clock. It stays set through recovery, clears on a one-cycle `loss_clr` pulse, and clears on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock, at least 4x the fastest monitored clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_in | input | 1 | Monitored master clock (asynchronous) |
| bclk_in | input | 1 | Monitored bit clock (asynchronous) |
| wclk_in | input | 1 | Monitored word clock (asynchronous) |
| loss_clr | input | 1 | Write-one-to-clear pulse for the sticky loss flag |
| power_down | output | 1 | 1 holds the converter datapath in power-down |
| out_hiz | output | 1 | 1 puts the analog output in high impedance |
| ldo_en | output | 1 | Regulator enable, always 1 |
| status | output | 2 | 00 in reset, 01 waiting or clock lost, 10 running |
| loss_sticky | output | 1 | Set by a master clock dropout while running |

## Verification
The bench brings up the clocks one at a time. A design that counted any single clock as enough to start would release power-down early. It stops the bit and word clocks while running, and a supervisor that watched every clock would then power down wrongly. It then lets the master clock alone return after a dropout, and a design that reused the start-up rule would stay stuck in power-down. The timeout edge is bracketed by checks taken 90 and 115 cycles after the master clock stops. A slow master clock with edges 40 cycles apart must keep running, while one with edges 150 cycles apart must never count as started, which catches an off-by-window counter.

// File: rtl/csup_pkg.sv
// Package: shared types for the clock-loss supervisor.
// Assumes nothing beyond IEEE 1800-2017 enums.
package csup_pkg;

    // Supervisor states; LOST reports the same status as WAIT.
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_LOST  = 2'd3
    } sup_state_e;

    localparam logic [1:0] STAT_RESET = 2'b00;
    localparam logic [1:0] STAT_WAIT  = 2'b01;
    localparam logic [1:0] STAT_RUN   = 2'b10;

endpackage

// File: rtl/csup_edge_sync.sv
// Module: csup_edge_sync
// Brings NUM_CLK asynchronous clocks into the reference domain through
// a two-flop synchroniser and emits a one-cycle pulse per transition.
// Assumes the reference clock is at least 4x faster than any input.
module csup_edge_sync #(
    parameter int NUM_CLK = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLK-1:0] async_in,
    output logic [NUM_CLK-1:0] edge_p
);

    generate
        for (genvar i = 0; i < NUM_CLK; i++) begin : g_ch
            logic [2:0] sh_q;

            // Shift the input through two sync flops and one history flop.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_q <= 3'b000;
                end else begin
                    sh_q <= {sh_q[1:0], async_in[i]};
                end
            end

            assign edge_p[i] = sh_q[1] ^ sh_q[2];
        end
    endgenerate

endmodule

// File: rtl/csup_activity.sv
// Module: csup_activity
// Declares one clock active once it has shown SEEN_EDGES edges, each
// within WINDOW_CYC reference cycles of the previous one. The flag is
// sticky until reset. Assumes edge_p is a one-cycle pulse.
module csup_activity #(
    parameter int WINDOW_CYC = 100,
    parameter int SEEN_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_p,
    output logic seen
);

    localparam int TW = $clog2(WINDOW_CYC + 1);
    localparam int CW = $clog2(SEEN_EDGES + 1);

    logic [TW-1:0] win_q;
    logic [CW-1:0] cnt_q;

    assign seen = (cnt_q == CW'(SEEN_EDGES));

    // Count edges inside the window; a window that runs out drops the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (!seen) begin
            if (edge_p) begin
                cnt_q <= cnt_q + 1'b1;
                win_q <= TW'(WINDOW_CYC);
            end else if (win_q != '0) begin
                win_q <= win_q - 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

endmodule

// File: rtl/csup_watchdog.sv
// Module: csup_watchdog
// Down-counter reloaded on every master clock edge. Reports expiry once
// TIMEOUT_CYC reference cycles have passed with no edge.
module csup_watchdog #(
    parameter int TIMEOUT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_p,
    output logic expired
);

    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    // Reload on an edge, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= TW'(TIMEOUT_CYC);
        end else if (edge_p) begin
            cnt_q <= TW'(TIMEOUT_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/csup_fsm.sv
// Module: csup_fsm
// Sequencing for the supervisor. Start-up needs all clocks active, a
// dropout is judged on the master clock alone, and the sticky loss flag
// lives here. Output stage registers are in the top.
module csup_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  all_seen,
    input  logic                  wd_expired,
    input  logic                  mclk_edge,
    input  logic                  loss_clr,
    output csup_pkg::sup_state_e  state,
    output logic                  sticky
);
    import csup_pkg::*;

    sup_state_e state_q, state_d;
    logic       sticky_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_WAIT;
            ST_WAIT:  if (all_seen)   state_d = ST_RUN;
            ST_RUN:   if (wd_expired) state_d = ST_LOST;
            ST_LOST:  if (mclk_edge)  state_d = ST_RUN;
            default:  state_d = ST_RESET;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Sticky loss flag: a new dropout wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
        end else if (state_q == ST_RUN && wd_expired) begin
            sticky_q <= 1'b1;
        end else if (loss_clr) begin
            sticky_q <= 1'b0;
        end
    end

    assign state  = state_q;
    assign sticky = sticky_q;

endmodule

// File: rtl/clk_loss_supervisor.sv
// Module: clk_loss_supervisor (top)
// Watches master, bit and word clocks from a reference clock and drives
// power-down, output high-impedance and regulator enable toward a
// converter datapath. Assumes the reference runs at least 4x the fastest
// monitored clock and that TIMEOUT_CYC is set for the wanted timeout
// (100 at 100 MHz for 1 us).
module clk_loss_supervisor #(
    parameter int TIMEOUT_CYC = 100,
    parameter int SEEN_EDGES  = 2
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       mclk_in,
    input  logic       bclk_in,
    input  logic       wclk_in,
    input  logic       loss_clr,
    output logic       power_down,
    output logic       out_hiz,
    output logic       ldo_en,
    output logic [1:0] status,
    output logic       loss_sticky
);
    import csup_pkg::*;

    localparam int NUM_CLK = 3;
    localparam int IDX_M   = 0;

    logic [NUM_CLK-1:0] edges;
    logic [NUM_CLK-1:0] seen;
    logic               all_seen;
    logic               wd_expired;
    logic               mclk_edge;
    sup_state_e         state_q;
    logic               pd_q;
    logic               hiz_q;

    csup_edge_sync #(.NUM_CLK(NUM_CLK)) u_sync (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .async_in ({wclk_in, bclk_in, mclk_in}),
        .edge_p   (edges)
    );

    generate
        for (genvar i = 0; i < NUM_CLK; i++) begin : g_act
            csup_activity #(
                .WINDOW_CYC (TIMEOUT_CYC),
                .SEEN_EDGES (SEEN_EDGES)
            ) u_act (
                .clk    (ref_clk),
                .rst_n  (rst_n),
                .edge_p (edges[i]),
                .seen   (seen[i])
            );
        end
    endgenerate

    assign all_seen  = &seen;
    assign mclk_edge = edges[IDX_M];

    csup_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .edge_p  (mclk_edge),
        .expired (wd_expired)
    );

    csup_fsm u_fsm (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .all_seen   (all_seen),
        .wd_expired (wd_expired),
        .mclk_edge  (mclk_edge),
        .loss_clr   (loss_clr),
        .state      (state_q),
        .sticky     (loss_sticky)
    );

    // Glitch-free registered output stage, one cycle behind the state.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            pd_q  <= 1'b1;
            hiz_q <= 1'b1;
        end else begin
            pd_q  <= (state_q != ST_RUN);
            hiz_q <= (state_q != ST_RUN);
        end
    end

    // Map internal state onto the three reported states.
    always_comb begin
        unique case (state_q)
            ST_RESET: status = STAT_RESET;
            ST_RUN:   status = STAT_RUN;
            default:  status = STAT_WAIT;
        endcase
    end

    assign power_down = pd_q;
    assign out_hiz    = hiz_q;
    assign ldo_en     = 1'b1;

endmodule

// File: rtl/csup_checker.sv
// Module: csup_checker
// Temporal checks for clk_loss_supervisor, bound to every instance.
module csup_checker (
    input  logic                 clk,
    input  logic                 rst_n,
    input  csup_pkg::sup_state_e state,
    input  logic                 all_seen,
    input  logic                 wd_expired,
    input  logic                 mclk_edge,
    input  logic                 power_down,
    input  logic                 out_hiz,
    input  logic [1:0]           status,
    input  logic                 loss_sticky
);
    import csup_pkg::*;

    // R1: reset gives the defined state one cycle later.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (status == STAT_RESET && power_down && out_hiz && !loss_sticky));

    // R3: no start without every clock proven active.
    a_r3_run_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !all_seen) |=> state != ST_RUN);

    // R5: no dropout unless the master clock watchdog ran out.
    a_r5_loss_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !wd_expired) |=> state == ST_RUN);

    // R6: a master clock edge alone resumes operation.
    a_r6_resume_on_mclk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOST && mclk_edge) |=> state == ST_RUN);

    // R8: outputs released one cycle after running.
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (!power_down && !out_hiz));

    // R8: outputs held otherwise.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> (power_down && out_hiz));

    // R9: a dropout while running sets the sticky flag.
    a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && wd_expired) |=> loss_sticky);

endmodule

bind clk_loss_supervisor csup_checker u_csup_chk (
    .clk         (ref_clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .all_seen    (all_seen),
    .wd_expired  (wd_expired),
    .mclk_edge   (mclk_edge),
    .power_down  (power_down),
    .out_hiz     (out_hiz),
    .status      (status),
    .loss_sticky (loss_sticky)
);

// File: tb/tb_clk_loss_supervisor.sv
module tb_clk_loss_supervisor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk = 1'b0, bclk = 1'b0, wclk = 1'b0;
    logic       loss_clr = 1'b0;
    logic       power_down, out_hiz, ldo_en, loss_sticky;
    logic [1:0] status;

    int checks = 0;
    int errors = 0;
    int hm = 0, hb = 0, hw = 0;
    int cm = 0, cb = 0, cw = 0;

    always #5 clk = ~clk;

    clk_loss_supervisor dut (
        .ref_clk     (clk),
        .rst_n       (rst_n),
        .mclk_in     (mclk),
        .bclk_in     (bclk),
        .wclk_in     (wclk),
        .loss_clr    (loss_clr),
        .power_down  (power_down),
        .out_hiz     (out_hiz),
        .ldo_en      (ldo_en),
        .status      (status),
        .loss_sticky (loss_sticky)
    );

    // Monitored clock generators: half period in reference cycles, 0 stops.
    always @(negedge clk) begin
        if (hm != 0) begin cm++; if (cm >= hm) begin cm = 0; mclk = ~mclk; end end
        if (hb != 0) begin cb++; if (cb >= hb) begin cb = 0; bclk = ~bclk; end end
        if (hw != 0) begin cw++; if (cw >= hw) begin cw = 0; wclk = ~wclk; end end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Columns: mclk half, bclk half, wclk half, cycles, pd, status, sticky.
    localparam int NV = 7;
    localparam int VEC [NV][7] = '{
        '{ 2,  0,  0, 300, 1, 1, 0},   // R3 master clock only
        '{ 2,  2,  0, 300, 1, 1, 0},   // R3 master and bit clock
        '{ 2,  2,  8, 300, 0, 2, 0},   // R3 all three running
        '{ 0,  2,  8, 300, 1, 1, 1},   // R5 master clock stopped
        '{ 2,  0,  0, 300, 0, 2, 1},   // R6 master clock alone returns
        '{ 3,  3, 12, 300, 0, 2, 1},   // R7 other rates
        '{40, 40, 40, 300, 0, 2, 1}    // R7 slow edges inside window
    };

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(3);
        chk("R1 status", status, 0);
        chk("R1 power_down", power_down, 1);
        chk("R1 out_hiz", out_hiz, 1);
        chk("R1 sticky", loss_sticky, 0);
        chk("R2 ldo_en in reset", ldo_en, 1);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(300);
        chk("R3 no clocks status", status, 1);
        chk("R3 no clocks pd", power_down, 1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            hm = VEC[i][0]; hb = VEC[i][1]; hw = VEC[i][2];
            wait_cyc(VEC[i][3]);
            chk($sformatf("R3/R5/R6/R7 vec%0d pd", i), power_down, VEC[i][4]);
            chk($sformatf("R8 vec%0d hiz", i), out_hiz, VEC[i][4]);
            chk($sformatf("R3/R5/R6/R7 vec%0d status", i), status, VEC[i][5]);
            chk($sformatf("R9 vec%0d sticky", i), loss_sticky, VEC[i][6]);
            if (i == 3) chk("R2 ldo_en in loss", ldo_en, 1);
        end

        // R9: clear pulse
        @(negedge clk); loss_clr = 1'b1;
        @(negedge clk); loss_clr = 1'b0;
        wait_cyc(2);
        chk("R9 cleared", loss_sticky, 0);

        // R5/R7: timeout boundary
        @(negedge clk); hm = 2; hb = 2; hw = 8;
        wait_cyc(50);
        @(negedge clk); hm = 0;
        wait_cyc(90);
        chk("R7 before timeout pd", power_down, 0);
        wait_cyc(25);
        chk("R5 after timeout pd", power_down, 1);
        chk("R9 set by loss", loss_sticky, 1);

        // R1: reset during loss
        @(negedge clk); rst_n = 1'b0;
        wait_cyc(3);
        chk("R1 reset status", status, 0);
        chk("R1 reset sticky", loss_sticky, 0);

        // R4: master edges 150 cycles apart never count
        @(negedge clk); hm = 150; rst_n = 1'b1;
        wait_cyc(400);
        chk("R4 slow mclk status", status, 1);
        chk("R4 slow mclk pd", power_down, 1);

        @(negedge clk); hm = 2;
        wait_cyc(300);
        chk("R3 restart status", status, 2);
        chk("R3 restart pd", power_down, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule